// File: doc/BRIEF.md
# Stack-Machine Variable Access Unit

This block carries out the variable load and store opcodes of a stack-oriented bytecode interpreter. Each accepted opcode byte names an access size, a base space (an address taken from the operand stack, or one of three base registers for the object, variable and local areas), an optional scaled index and one of four actions. The actions are: read memory and push the value, pop a value and write it, hand the computed target to a separate operator stage, or push the target address itself. A one-byte short form reaches the first eight long variables of the variable or local area without a separate offset.

The unit owns a 16-entry operand stack. The interpreter around it can push or pop single entries through a side port while no opcode is in flight. Memory is reached through a 32-bit request channel and a read response channel, both valid/ready. A request stays up with a stable address, write flag, data and byte enables until `mem_req_ready` is seen high at a clock edge. A read then waits, with `mem_rsp_ready` high, for however many cycles `mem_rsp_valid` takes. Opcodes arrive on a valid/ready channel and `op_ready` is high only while the unit is idle.

Top module: `stack_var_access`

## Requirements
- R1: An opcode in 0x40..0x7F is a short long-access. Bit 5 picks the area (0 = variable base, 1 = local base), bits 4:2 give a slot n of 0..7, and the target byte address is that base plus 4*n.
- R2: An opcode in 0x80..0xDF is a general access. Bits 6:5 give the size (00 byte, 01 word, 10 long) and are reported in `asg_size` with the same encoding.
- R3: In the general form bits 3:2 pick the base: 00 pops it from the stack, 01 object base, 10 variable base, 11 local base.
- R4: When bit 4 of a general opcode is 1, the top of stack is popped as an index, scaled by the size (1, 2 or 4 bytes) and added to the base. Any popped base is the entry below it. When bit 4 is 0, no index is used.
- R5: Action bits 1:0 = 00 read the target and push it. Byte and word reads take lane addr[1:0] or half addr[1] of the 32-bit word and are zero-extended.
- R6: Action 01 pops a value from below any index and base and writes it. Byte and word writes assert only the addressed byte enables, so the other lanes of the word stay unchanged.
- R7: Action 10 makes no memory access. It pops index and base as needed and gives a one-cycle `asg_valid` together with `op_done`, carrying the target address and size.
- R8: Action 11 pushes the target byte address onto the stack.
- R9: Opcodes 0xC8..0xCF give the same results as the short opcodes for slot 0 with the same area and action.
- R10: The stack holds 16 entries. An opcode that would pop more entries than are present, or push onto a full stack, sets the sticky `stk_err`, makes no memory access and leaves the stack unchanged. `stk_err` is cleared only by reset.
- R11: Every accepted opcode ends with a single-cycle `op_done`. Opcodes below 0x40 and at 0xE0 or above complete this way with no other effect.
- R12: A memory request holds its address and direction until accepted, and a read completes only when `mem_rsp_valid` is seen.
- R13: While idle with `op_valid` low, `stk_push_valid` pushes `stk_push_data`, or else `stk_pop` drops the top entry. A push onto a full stack or a pop from an empty stack sets `stk_err` and changes nothing else. `stk_top` shows the top entry (0 when empty) and `stk_depth` the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit idle, opcode taken |
| op_code | input | 8 | Opcode byte |
| obj_base | input | 32 | Object area base address |
| var_base | input | 32 | Variable area base address |
| loc_base | input | 32 | Local area base address |
| stk_push_valid | input | 1 | Side-port push strobe |
| stk_push_data | input | 32 | Side-port push value |
| stk_pop | input | 1 | Side-port pop strobe |
| stk_top | output | 32 | Top stack entry |
| stk_depth | output | 5 | Stack entry count |
| stk_err | output | 1 | Sticky stack fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address |
| mem_req_be | output | 4 | Byte enables for writes |
| mem_req_wdata | output | 32 | Lane-replicated write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Waiting for read data |
| mem_rsp_data | input | 32 | Read word |
| op_done | output | 1 | Opcode complete pulse |
| asg_valid | output | 1 | Assignment handoff pulse |
| asg_addr | output | 32 | Assignment target address |
| asg_size | output | 2 | Assignment target size |

## Verification
An indexed general write with a stack-supplied base (0x91, 0xB1, 0xD1) removes three entries in one cycle: the index from the top, the base beneath it and the value beneath that. This is the point where two address components and the data cross. The sweep pushes three distinct numbers before every such opcode and judges the result from the whole memory word written, the remaining stack depth and the fact that neighbouring lanes keep their old bytes. Swapping any two pops shows up as a wrong address or wrong data. A short read and a handoff pulse finishing in the same cycle as `op_done` is covered by watching `asg_valid` at the completion edge.

// File: rtl/vau_pkg.sv
package vau_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} vau_size_e;
  typedef enum logic [1:0] {BS_POP = 2'd0, BS_OBJ = 2'd1, BS_VAR = 2'd2, BS_LOC = 2'd3} vau_base_e;
  typedef enum logic [1:0] {ACT_READ = 2'd0, ACT_WRITE = 2'd1, ACT_ASSIGN = 2'd2, ACT_ADDR = 2'd3} vau_act_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_RSP = 2'd2, S_WR = 2'd3} vau_state_e;

  typedef struct packed {
    logic      valid;
    vau_size_e size;
    vau_base_e base;
    logic      indexed;
    logic [4:0] off;
    vau_act_e  act;
  } vau_dec_t;
endpackage

// File: rtl/vau_decode.sv
module vau_decode
  import vau_pkg::*;
(
  input  logic [7:0] code,
  output vau_dec_t   dec
);
  always_comb begin
    dec = '0;
    dec.act = vau_act_e'(code[1:0]);
    if (code[7:6] == 2'b01) begin
      dec.valid   = 1'b1;
      dec.size    = SZ_LONG;
      dec.base    = code[5] ? BS_LOC : BS_VAR;
      dec.indexed = 1'b0;
      dec.off     = {code[4:2], 2'b00};
    end else if (code[7] && code[6:5] != 2'b11) begin
      dec.valid   = 1'b1;
      dec.size    = vau_size_e'(code[6:5]);
      dec.base    = vau_base_e'(code[3:2]);
      dec.indexed = code[4];
      dec.off     = '0;
    end
  end
endmodule

// File: rtl/vau_stack.sv
module vau_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pop_cnt,
  input  logic          push_en,
  input  logic [W-1:0]  push_data,
  output logic [W-1:0]  peek0,
  output logic [W-1:0]  peek1,
  output logic [W-1:0]  peek2,
  output logic [CW-1:0] depth
);
  logic [W-1:0]  ent [DEPTH];
  logic [CW-1:0] wp, i0, i1, i2;

  assign wp = depth - CW'(pop_cnt);
  assign i0 = depth - CW'(1);
  assign i1 = depth - CW'(2);
  assign i2 = depth - CW'(3);

  assign peek0 = (depth > CW'(0)) ? ent[i0[IW-1:0]] : '0;
  assign peek1 = (depth > CW'(1)) ? ent[i1[IW-1:0]] : '0;
  assign peek2 = (depth > CW'(2)) ? ent[i2[IW-1:0]] : '0;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                        ent[k] <= '0;
      else if (push_en && wp == CW'(k))  ent[k] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) depth <= '0;
    else        depth <= wp + CW'(push_en);
  end
endmodule

// File: rtl/vau_lane.sv
module vau_lane
  import vau_pkg::*;
(
  input  vau_size_e          size,
  input  logic [1:0]         addr_lo,
  input  logic [WORD_W-1:0]  wval,
  input  logic [WORD_W-1:0]  rword,
  output logic [LANES-1:0]   be,
  output logic [WORD_W-1:0]  wword,
  output logic [WORD_W-1:0]  rval
);
  logic [WORD_W-1:0] sh;
  always_comb begin
    sh = '0;
    case (size)
      SZ_BYTE: begin
        be    = LANES'(1) << addr_lo;
        wword = {LANES{wval[7:0]}};
        sh    = rword >> {addr_lo, 3'b000};
        rval  = {{(WORD_W-8){1'b0}}, sh[7:0]};
      end
      SZ_WORD: begin
        be    = addr_lo[1] ? 4'b1100 : 4'b0011;
        wword = {2{wval[15:0]}};
        sh    = rword >> {addr_lo[1], 4'b0000};
        rval  = {{(WORD_W-16){1'b0}}, sh[15:0]};
      end
      default: begin
        be    = '1;
        wword = wval;
        rval  = rword;
      end
    endcase
  end
endmodule

// File: rtl/stack_var_access.sv
module stack_var_access
  import vau_pkg::*;
#(
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             op_valid,
  output logic                             op_ready,
  input  logic [7:0]                       op_code,
  input  logic [ADDR_W-1:0]                obj_base,
  input  logic [ADDR_W-1:0]                var_base,
  input  logic [ADDR_W-1:0]                loc_base,
  input  logic                             stk_push_valid,
  input  logic [31:0]                      stk_push_data,
  input  logic                             stk_pop,
  output logic [31:0]                      stk_top,
  output logic [$clog2(STACK_DEPTH+1)-1:0] stk_depth,
  output logic                             stk_err,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic                             mem_req_we,
  output logic [ADDR_W-1:0]                mem_req_addr,
  output logic [3:0]                       mem_req_be,
  output logic [31:0]                      mem_req_wdata,
  input  logic                             mem_rsp_valid,
  output logic                             mem_rsp_ready,
  input  logic [31:0]                      mem_rsp_data,
  output logic                             op_done,
  output logic                             asg_valid,
  output logic [ADDR_W-1:0]                asg_addr,
  output logic [1:0]                       asg_size
);
  localparam int CW = $clog2(STACK_DEPTH + 1);

  vau_state_e        state;
  vau_dec_t          dec;
  vau_size_e         l_size;
  logic [ADDR_W-1:0] l_addr, eff, base_sel, scaled;
  logic [31:0]       top0, top1, top2, value, push_data, lane_w, lane_r;
  logic [3:0]        lane_be;
  logic [1:0]        need, pop_cnt;
  logic              acc, fault, go, push_en, ext_ok, pop_base;
  logic              ext_push, ext_pop, full, empty;

  vau_decode u_dec (.code(op_code), .dec(dec));

  vau_stack #(.DEPTH(STACK_DEPTH), .W(32)) u_stk (
    .clk(clk), .rst_n(rst_n), .pop_cnt(pop_cnt), .push_en(push_en),
    .push_data(push_data), .peek0(top0), .peek1(top1), .peek2(top2), .depth(stk_depth)
  );

  vau_lane u_lane (
    .size   (state == S_IDLE ? dec.size : l_size),
    .addr_lo(state == S_IDLE ? eff[1:0] : l_addr[1:0]),
    .wval(value), .rword(mem_rsp_data), .be(lane_be), .wword(lane_w), .rval(lane_r)
  );

  assign op_ready = (state == S_IDLE);
  assign acc      = op_valid && op_ready;
  assign full     = (stk_depth == CW'(STACK_DEPTH));
  assign empty    = (stk_depth == CW'(0));
  assign ext_ok   = op_ready && !op_valid;
  assign ext_push = ext_ok && stk_push_valid;
  assign ext_pop  = ext_ok && !stk_push_valid && stk_pop;
  assign stk_top  = top0;
  assign pop_base = (dec.base == BS_POP);

  // Stack order from the top: index, then base, then value to store.
  always_comb begin
    need = 2'(dec.indexed) + 2'(pop_base) + 2'(dec.act == ACT_WRITE);
    case ({dec.indexed, pop_base})
      2'b00:   value = top0;
      2'b11:   value = top2;
      default: value = top1;
    endcase
    case (dec.base)
      BS_POP:  base_sel = ADDR_W'(dec.indexed ? top1 : top0);
      BS_OBJ:  base_sel = obj_base;
      BS_VAR:  base_sel = var_base;
      default: base_sel = loc_base;
    endcase
    scaled = dec.indexed ? (ADDR_W'(top0) << dec.size) : '0;
    eff    = base_sel + scaled + ADDR_W'(dec.off);
    fault  = dec.valid && ((stk_depth < CW'(need)) ||
             ((dec.act == ACT_READ || dec.act == ACT_ADDR) && need == 2'd0 && full));
    go     = acc && dec.valid && !fault;
  end

  always_comb begin
    pop_cnt   = 2'd0;
    push_en   = 1'b0;
    push_data = '0;
    if (go) begin
      pop_cnt   = need;
      push_en   = (dec.act == ACT_ADDR);
      push_data = 32'(eff);
    end else if (state == S_RSP && mem_rsp_valid) begin
      push_en   = 1'b1;
      push_data = lane_r;
    end else if (ext_push && !full) begin
      push_en   = 1'b1;
      push_data = stk_push_data;
    end else if (ext_pop && !empty) begin
      pop_cnt   = 2'd1;
    end
  end

  assign mem_req_valid = (state == S_RD) || (state == S_WR);
  assign mem_req_we    = (state == S_WR);
  assign mem_rsp_ready = (state == S_RSP);
  assign mem_req_addr  = l_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; l_addr <= '0; l_size <= SZ_BYTE;
      mem_req_be <= '0; mem_req_wdata <= '0;
      op_done <= 1'b0; asg_valid <= 1'b0; asg_addr <= '0; asg_size <= '0; stk_err <= 1'b0;
    end else begin
      op_done   <= 1'b0;
      asg_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (acc) begin
            op_done <= !go || dec.act == ACT_ASSIGN || dec.act == ACT_ADDR;
            if (fault) stk_err <= 1'b1;
            if (go) begin
              l_addr <= eff;
              l_size <= dec.size;
              case (dec.act)
                ACT_READ:  state <= S_RD;
                ACT_WRITE: begin
                  state <= S_WR; mem_req_be <= lane_be; mem_req_wdata <= lane_w;
                end
                ACT_ASSIGN: begin
                  asg_valid <= 1'b1; asg_addr <= eff; asg_size <= dec.size;
                end
                default: ;
              endcase
            end
          end else if ((ext_push && full) || (ext_pop && empty)) begin
            stk_err <= 1'b1;
          end
        end
        S_RD:  if (mem_req_ready) state <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin state <= S_IDLE; op_done <= 1'b1; end
        default: if (mem_req_ready) begin state <= S_IDLE; op_done <= 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/vau_checker.sv
module vau_checker #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [3:0]    mem_req_be,
  input logic          mem_rsp_ready,
  input logic          op_done,
  input logic          asg_valid,
  input logic          stk_err,
  input logic [CW-1:0] stk_depth
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R12
  AST_BE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> ($countones(mem_req_be) == 1 || $countones(mem_req_be) == 2 ||
                                     $countones(mem_req_be) == 4)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err); // R10
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= CW'(DEPTH)); // R10
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_err) |-> !mem_req_valid); // R10
  AST_ASG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> op_done && !mem_req_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !mem_req_valid && !mem_rsp_ready); // R11
endmodule

bind stack_var_access vau_checker #(.DEPTH(STACK_DEPTH), .AW(ADDR_W)) u_vau_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_be(mem_req_be), .mem_rsp_ready(mem_rsp_ready), .op_done(op_done),
  .asg_valid(asg_valid), .stk_err(stk_err), .stk_depth(stk_depth)
);

// File: tb/test_stack_var_access.sv
module test_stack_var_access;
  localparam logic [31:0] OBJ = 32'h40, VARB = 32'h80, LOCB = 32'hC0;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, stk_push_valid = 0, stk_pop = 0;
  logic [7:0] op_code = 0;
  logic [31:0] stk_push_data = 0, stk_top, mem_req_addr, mem_req_wdata, asg_addr;
  logic [31:0] mem_rsp_data = 0;
  logic [4:0] stk_depth;
  logic [3:0] mem_req_be;
  logic [1:0] asg_size;
  logic stk_err, op_ready, mem_req_valid, mem_req_we, mem_rsp_ready, op_done, asg_valid;
  logic mem_req_ready = 0, mem_rsp_valid = 0;

  always #5 clk = ~clk;

  stack_var_access i_stack_var_access (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .obj_base(OBJ), .var_base(VARB), .loc_base(LOCB),
    .stk_push_valid(stk_push_valid), .stk_push_data(stk_push_data), .stk_pop(stk_pop),
    .stk_top(stk_top), .stk_depth(stk_depth), .stk_err(stk_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .op_done(op_done), .asg_valid(asg_valid), .asg_addr(asg_addr), .asg_size(asg_size)
  );

  logic [31:0] mem_m [64];
  logic [31:0] ref_m [64];
  int n_vec = 0, n_bad = 0, req_count = 0, lfsr = 7;
  bit finished = 0;
  logic got_asg;
  logic [31:0] got_aaddr;
  logic [1:0] got_asize;

  // Memory environment with varying wait states.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        lfsr = (lfsr * 1103 + 17) % 9973;
        repeat (lfsr % 3) @(negedge clk);
        mem_req_ready = 1;
        req_count++;
        if (mem_req_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_req_be[b]) mem_m[mem_req_addr[7:2]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
          @(negedge clk);
          mem_req_ready = 0;
        end else begin
          logic [5:0] wa;
          wa = mem_req_addr[7:2];
          @(negedge clk);
          mem_req_ready = 0;
          repeat (lfsr % 4) @(negedge clk);
          mem_rsp_valid = 1;
          mem_rsp_data  = mem_m[wa];
          @(negedge clk);
          mem_rsp_valid = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push_s(input logic [31:0] v);
    stk_push_valid = 1; stk_push_data = v;
    @(negedge clk);
    stk_push_valid = 0;
  endtask

  task automatic pop_s();
    stk_pop = 1;
    @(negedge clk);
    stk_pop = 0;
  endtask

  task automatic run_op(input logic [7:0] op);
    int t;
    op_valid = 1; op_code = op;
    @(negedge clk);
    op_valid = 0;
    t = 0;
    while (!op_done && t < 200) begin @(negedge clk); t++; end
    if (!op_done) chk("R11 done timeout", 32'd0, 32'd1);
    got_asg = asg_valid; got_aaddr = asg_addr; got_asize = asg_size;
  endtask

  function automatic logic [31:0] ext_val(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0: return (w >> (a[1:0] * 8)) & 32'hFF;
      2'd1: return (w >> (a[1] * 16)) & 32'hFFFF;
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz,
                                        input logic [31:0] v);
    logic [31:0] r;
    r = w;
    case (sz)
      2'd0: r[a[1:0]*8 +: 8] = v[7:0];
      2'd1: r[a[1]*16 +: 16] = v[15:0];
      default: r = v;
    endcase
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, v, pb, idx, r1, r2;
    logic [1:0] sz;
    int rc;
    for (int k = 0; k < 64; k++) begin
      mem_m[k] = 32'hA5000000 ^ (k * 32'h01030507);
      ref_m[k] = mem_m[k];
    end
    do_reset();
    chk("R10 reset depth", 32'(stk_depth), 0);
    chk("R10 reset err", 32'(stk_err), 0);
    chk("R11 reset done", 32'(op_done), 0);
    chk("R12 reset req", 32'(mem_req_valid), 0);
    chk("R11 reset ready", 32'(op_ready), 1);

    // R1 short-form sweep
    for (int op = 8'h40; op <= 8'h7F; op++) begin
      a = (op[5] ? LOCB : VARB) + 32'(op[4:2]) * 4;
      case (op[1:0])
        2'd0: begin
          run_op(8'(op));
          chk("R1 R5 short read", stk_top, ref_m[a[7:2]]);
          chk("R5 depth", 32'(stk_depth), 1);
          pop_s();
        end
        2'd1: begin
          v = 32'h5A000000 | (32'(op) * 32'h10101);
          push_s(v);
          run_op(8'(op));
          ref_m[a[7:2]] = v;
          chk("R1 R6 short write", mem_m[a[7:2]], v);
          chk("R6 depth", 32'(stk_depth), 0);
        end
        2'd2: begin
          run_op(8'(op));
          chk("R7 short handoff", 32'(got_asg), 1);
          chk("R7 short addr", got_aaddr, a);
          chk("R2 R7 short size", 32'(got_asize), 2);
        end
        default: begin
          run_op(8'(op));
          chk("R1 R8 short addr push", stk_top, a);
          pop_s();
        end
      endcase
    end

    // R2 R3 R4 general sweep
    for (int op = 8'h80; op <= 8'hDF; op++) begin
      sz  = op[6:5];
      idx = 32'(op % 5) + 1;
      pb  = 32'h20 + 32'(op % 3) * 4;
      case (op[3:2])
        2'd0: a = pb;
        2'd1: a = OBJ;
        2'd2: a = VARB;
        default: a = LOCB;
      endcase
      if (op[4]) a = a + (idx << sz);
      v = 32'hC3000000 ^ (32'(op) * 32'h00070B0D);
      if (op[1:0] == 2'd1) push_s(v);
      if (op[3:2] == 2'd0) push_s(pb);
      if (op[4]) push_s(idx);
      case (op[1:0])
        2'd0: begin
          run_op(8'(op));
          chk("R2 R3 R4 R5 read value", stk_top, ext_val(ref_m[a[7:2]], a, sz));
          chk("R5 read depth", 32'(stk_depth), 1);
          pop_s();
        end
        2'd1: begin
          run_op(8'(op));
          ref_m[a[7:2]] = merge(ref_m[a[7:2]], a, sz, v);
          chk("R2 R3 R4 R6 write word", mem_m[a[7:2]], ref_m[a[7:2]]);
          chk("R6 write depth", 32'(stk_depth), 0);
        end
        2'd2: begin
          run_op(8'(op));
          chk("R7 handoff", 32'(got_asg), 1);
          chk("R3 R4 R7 handoff addr", got_aaddr, a);
          chk("R2 R7 handoff size", 32'(got_asize), 32'(sz));
          chk("R7 handoff depth", 32'(stk_depth), 0);
        end
        default: begin
          run_op(8'(op));
          chk("R3 R4 R8 addr push", stk_top, a);
          chk("R8 depth", 32'(stk_depth), 1);
          pop_s();
        end
      endcase
    end

    // R9 equivalence of long general forms with short slot 0
    for (int k = 0; k < 8; k++) begin
      if (k % 4 == 1 || k % 4 == 2) continue;
      run_op(8'(8'hC8 + k));
      r1 = stk_top; pop_s();
      run_op(8'((k < 4 ? 8'h40 : 8'h60) + k % 4));
      r2 = stk_top; pop_s();
      chk("R9 general vs short", r1, r2);
    end

    // R11 done is a single pulse
    run_op(8'h40);
    @(negedge clk);
    chk("R11 done pulse width", 32'(op_done), 0);
    pop_s();

    // R11 out-of-range opcodes
    push_s(32'd7);
    rc = req_count;
    run_op(8'h00); run_op(8'h3F); run_op(8'hE0); run_op(8'hFF);
    chk("R11 ignored depth", 32'(stk_depth), 1);
    chk("R11 ignored top", stk_top, 7);
    chk("R11 ignored err", 32'(stk_err), 0);
    chk("R11 ignored no access", 32'(req_count), 32'(rc));
    pop_s();

    // R13 side port
    push_s(32'h11); push_s(32'h22);
    chk("R13 push top", stk_top, 32'h22);
    pop_s();
    chk("R13 pop top", stk_top, 32'h11);
    chk("R13 pop depth", 32'(stk_depth), 1);
    pop_s();

    // R10 overflow on a push-type opcode
    for (int k = 0; k < 16; k++) push_s(32'(k * 3));
    chk("R10 full depth", 32'(stk_depth), 16);
    chk("R10 no err at full", 32'(stk_err), 0);
    rc = req_count;
    run_op(8'h40);
    chk("R10 overflow err", 32'(stk_err), 1);
    chk("R10 overflow depth", 32'(stk_depth), 16);
    chk("R10 overflow top", stk_top, 45);
    chk("R10 overflow no access", 32'(req_count), 32'(rc));

    // R10 underflow on a write
    do_reset();
    chk("R10 err cleared by reset", 32'(stk_err), 0);
    rc = req_count;
    run_op(8'h41);
    chk("R10 underflow err", 32'(stk_err), 1);
    chk("R10 underflow no access", 32'(req_count), 32'(rc));
    chk("R10 underflow memory", mem_m[VARB[7:2]], ref_m[VARB[7:2]]);
    chk("R10 underflow depth", 32'(stk_depth), 0);

    // R13 side-port faults
    do_reset();
    pop_s();
    chk("R13 empty pop err", 32'(stk_err), 1);
    chk("R13 empty pop depth", 32'(stk_depth), 0);
    do_reset();
    for (int k = 0; k < 16; k++) push_s(32'(k));
    push_s(32'h99);
    chk("R13 full push err", 32'(stk_err), 1);
    chk("R13 full push top", stk_top, 15);

    for (int k = 0; k < 64; k++) chk("R6 final memory", mem_m[k], ref_m[k]);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule